// File: doc/BRIEF.md
# Host Window Bridge with Page Table

This block connects a host-facing request port to the on-chip fabric. Each host request is steered by its address into one of three windows. A hit in the control window or the bulk window is sent out on that window's own outbound link, carrying the offset inside the window. A hit in the table window reads or writes an embedded page table. A read returns its entry on a response channel. A request that hits no window is dropped and sets a sticky error flag.

In the other direction, cores send requests on a host-access link using a narrow core address. The page-number bits of that address select a table entry, which holds a physical page number. The in-page offset bits pass through unchanged. The result is posted as a host packet with the full physical address. Host software fills the table through the table window before cores use this path. Every channel uses a valid/ready handshake, and every output is taken straight from a register.

Top module: `host_window_bridge`

## Requirements
- R1: A host request whose address lies in [CTRL_BASE, CTRL_BASE+CTRL_SIZE) is forwarded once on the control link. It carries the same write flag and data, and its address is the host address minus CTRL_BASE.
- R2: A host request whose address lies in [BULK_BASE, BULK_BASE+BULK_SIZE) is forwarded once on the bulk link. It carries the same write flag and data, and its address is the host address minus BULK_BASE.
- R3: The table window starts at PT_BASE and holds one 4-byte word per entry. Bits [1:0] of the offset are ignored, and the bits above them select the entry. A write stores the low PPN_W bits of the write data. A read returns the stored entry, zero-extended, on the response channel in the cycle after it is accepted.
- R4: A host request that hits no window is accepted and produces no output on any link. It sets win_err, which stays high until reset.
- R5: A core request is emitted as a host packet in the cycle after it is accepted. The packet address is {table[core_addr[CORE_AW-1:PAGE_OFF_W]], core_addr[PAGE_OFF_W-1:0]}. The write flag and data are unchanged.
- R6: In a cycle where the host writes the table entry that a valid core request indexes, core_ready is low. The translation then uses the newly written entry.
- R7: While an output's valid is high and its ready is low, the output keeps valid high and keeps its contents stable. No request is lost or duplicated under backpressure.
- R8: After reset, all output valids and win_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request accepted |
| h_req_write | input | 1 | Host request is a write |
| h_req_addr | input | HADDR_W | Host byte address |
| h_req_wdata | input | DATA_W | Host write data |
| h_rsp_valid | output | 1 | Table read response valid |
| h_rsp_ready | input | 1 | Host takes the response |
| h_rsp_data | output | DATA_W | Table entry, zero-extended |
| ctl_valid | output | 1 | Control link request valid |
| ctl_ready | input | 1 | Control link accepts |
| ctl_write | output | 1 | Control link write flag |
| ctl_addr | output | HADDR_W | Offset in control window |
| ctl_wdata | output | DATA_W | Control link write data |
| blk_valid | output | 1 | Bulk link request valid |
| blk_ready | input | 1 | Bulk link accepts |
| blk_write | output | 1 | Bulk link write flag |
| blk_addr | output | HADDR_W | Offset in bulk window |
| blk_wdata | output | DATA_W | Bulk link write data |
| core_valid | input | 1 | Core host-access request valid |
| core_ready | output | 1 | Core request accepted |
| core_write | input | 1 | Core request is a write |
| core_addr | input | CORE_AW | Core address: page number and offset |
| core_wdata | input | DATA_W | Core write data |
| pkt_valid | output | 1 | Outbound host packet valid |
| pkt_ready | input | 1 | Host transport accepts the packet |
| pkt_write | output | 1 | Packet write flag |
| pkt_addr | output | PHYS_W | Translated physical address |
| pkt_wdata | output | DATA_W | Packet write data |
| win_err | output | 1 | Sticky flag for an address outside all windows |

## Verification
The hardest case to reach is the collision. A host write to a table entry must land in the same cycle as a valid core request for that same page. Only then does the stall and the old/new ordering come into play. Random traffic alone rarely lines this up, so the stimulus draws the core page from the page of a pending host table write about a third of the time, and a directed case forces the collision once with every ready high. Random ready levels on all four outputs keep each output register stalled often, so the hold rules are exercised while new requests keep arriving behind them.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  typedef enum logic [1:0] {
    WIN_CTRL = 2'd0,
    WIN_BULK = 2'd1,
    WIN_PT   = 2'd2,
    WIN_NONE = 2'd3
  } win_e;
endpackage

// File: rtl/hwb_decode.sv
module hwb_decode
  import hwb_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] CTRL_BASE = '0,
  parameter logic [AW-1:0] CTRL_SIZE = '0,
  parameter logic [AW-1:0] BULK_BASE = '0,
  parameter logic [AW-1:0] BULK_SIZE = '0,
  parameter logic [AW-1:0] PT_BASE   = '0,
  parameter logic [AW-1:0] PT_SIZE   = '0
) (
  input  logic [AW-1:0] addr,
  output win_e          win,
  output logic [AW-1:0] offset
);
  function automatic logic inside_win(input logic [AW-1:0] a, b, s);
    return (a >= b) && ((a - b) < s);
  endfunction

  // control first, then bulk, then table when windows overlap
  always_comb begin
    win    = WIN_NONE;
    offset = '0;
    if (inside_win(addr, CTRL_BASE, CTRL_SIZE)) begin
      win    = WIN_CTRL;
      offset = addr - CTRL_BASE;
    end else if (inside_win(addr, BULK_BASE, BULK_SIZE)) begin
      win    = WIN_BULK;
      offset = addr - BULK_BASE;
    end else if (inside_win(addr, PT_BASE, PT_SIZE)) begin
      win    = WIN_PT;
      offset = addr - PT_BASE;
    end
  end
endmodule

// File: rtl/hwb_slot.sv
module hwb_slot #(
  parameter int W = 65
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         free,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] dout
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst)        valid <= 1'b0;
    else if (load)  valid <= 1'b1;
    else if (ready) valid <= 1'b0;
    if (load) dout <= din;
  end
endmodule

// File: rtl/hwb_ptable.sv
module hwb_ptable #(
  parameter int IDX_W = 8,
  parameter int ENT_W = 28
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [ENT_W-1:0] a_wdata,
  output logic [ENT_W-1:0] a_rdata,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_idx,
  output logic [ENT_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];

  // port A: host side, read and write
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_idx] <= a_wdata;
      else      a_rdata    <= mem[a_idx];
    end
  end

  // port B: translation side, read only
  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_idx];
  end
endmodule

// File: rtl/host_window_bridge.sv
module host_window_bridge
  import hwb_pkg::*;
#(
  parameter int HADDR_W    = 32,
  parameter int DATA_W     = 32,
  parameter int CORE_AW    = 20,
  parameter int PAGE_OFF_W = 12,
  parameter int PHYS_W     = 40,
  parameter logic [HADDR_W-1:0] CTRL_BASE = 32'h0000_0000,
  parameter logic [HADDR_W-1:0] CTRL_SIZE = 32'h0000_1000,
  parameter logic [HADDR_W-1:0] BULK_BASE = 32'h1000_0000,
  parameter logic [HADDR_W-1:0] BULK_SIZE = 32'h1000_0000,
  parameter logic [HADDR_W-1:0] PT_BASE   = 32'h3000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               h_req_valid,
  output logic               h_req_ready,
  input  logic               h_req_write,
  input  logic [HADDR_W-1:0] h_req_addr,
  input  logic [DATA_W-1:0]  h_req_wdata,
  output logic               h_rsp_valid,
  input  logic               h_rsp_ready,
  output logic [DATA_W-1:0]  h_rsp_data,
  output logic               ctl_valid,
  input  logic               ctl_ready,
  output logic               ctl_write,
  output logic [HADDR_W-1:0] ctl_addr,
  output logic [DATA_W-1:0]  ctl_wdata,
  output logic               blk_valid,
  input  logic               blk_ready,
  output logic               blk_write,
  output logic [HADDR_W-1:0] blk_addr,
  output logic [DATA_W-1:0]  blk_wdata,
  input  logic               core_valid,
  output logic               core_ready,
  input  logic               core_write,
  input  logic [CORE_AW-1:0] core_addr,
  input  logic [DATA_W-1:0]  core_wdata,
  output logic               pkt_valid,
  input  logic               pkt_ready,
  output logic               pkt_write,
  output logic [PHYS_W-1:0]  pkt_addr,
  output logic [DATA_W-1:0]  pkt_wdata,
  output logic               win_err
);
  localparam int PAGE_IDX_W = CORE_AW - PAGE_OFF_W;
  localparam int PT_DEPTH   = 1 << PAGE_IDX_W;
  localparam int PPN_W      = PHYS_W - PAGE_OFF_W;
  localparam logic [HADDR_W-1:0] PT_SIZE = HADDR_W'(PT_DEPTH * 4);
  localparam int FWD_W      = 1 + HADDR_W + DATA_W;

  win_e               win;
  logic [HADDR_W-1:0] win_off;
  logic [PAGE_IDX_W-1:0] pt_idx, core_idx;
  logic h_fire, pt_wr, pt_rd, rsp_free, collide, core_fire;
  logic [1:0] slot_load, slot_free;
  logic [FWD_W-1:0] slot_dout [2];
  logic [PPN_W-1:0] a_rdata, b_rdata;
  logic [PAGE_OFF_W-1:0] off_q;

  hwb_decode #(
    .AW(HADDR_W), .CTRL_BASE(CTRL_BASE), .CTRL_SIZE(CTRL_SIZE),
    .BULK_BASE(BULK_BASE), .BULK_SIZE(BULK_SIZE),
    .PT_BASE(PT_BASE), .PT_SIZE(PT_SIZE)
  ) u_dec (.addr(h_req_addr), .win(win), .offset(win_off));

  assign pt_idx   = win_off[PAGE_IDX_W+1:2];
  assign core_idx = core_addr[CORE_AW-1:PAGE_OFF_W];
  assign rsp_free = !h_rsp_valid || h_rsp_ready;

  always_comb begin
    unique case (win)
      WIN_CTRL: h_req_ready = slot_free[0];
      WIN_BULK: h_req_ready = slot_free[1];
      WIN_PT:   h_req_ready = h_req_write || rsp_free;
      default:  h_req_ready = 1'b1;
    endcase
  end

  assign h_fire = h_req_valid && h_req_ready;
  assign pt_wr  = h_fire && (win == WIN_PT) && h_req_write;
  assign pt_rd  = h_fire && (win == WIN_PT) && !h_req_write;
  assign slot_load[0] = h_fire && (win == WIN_CTRL);
  assign slot_load[1] = h_fire && (win == WIN_BULK);

  // one forwarding register per outbound window link
  logic [1:0] slot_valid, slot_ready;
  assign slot_ready = {blk_ready, ctl_ready};

  for (genvar g = 0; g < 2; g++) begin : g_fwd
    hwb_slot #(.W(FWD_W)) u_slot (
      .clk(clk), .rst(rst), .load(slot_load[g]),
      .din({h_req_write, win_off, h_req_wdata}),
      .free(slot_free[g]), .valid(slot_valid[g]),
      .ready(slot_ready[g]), .dout(slot_dout[g])
    );
  end

  assign ctl_valid = slot_valid[0];
  assign {ctl_write, ctl_addr, ctl_wdata} = slot_dout[0];
  assign blk_valid = slot_valid[1];
  assign {blk_write, blk_addr, blk_wdata} = slot_dout[1];

  // a same-entry host write wins the cycle; the core retries next cycle
  assign collide    = pt_wr && (pt_idx == core_idx);
  assign core_ready = (!pkt_valid || pkt_ready) && !collide;
  assign core_fire  = core_valid && core_ready;

  hwb_ptable #(.IDX_W(PAGE_IDX_W), .ENT_W(PPN_W)) u_pt (
    .clk(clk),
    .a_en(pt_wr || pt_rd), .a_we(pt_wr), .a_idx(pt_idx),
    .a_wdata(h_req_wdata[PPN_W-1:0]), .a_rdata(a_rdata),
    .b_en(core_fire), .b_idx(core_idx), .b_rdata(b_rdata)
  );

  assign h_rsp_data = {{(DATA_W-PPN_W){1'b0}}, a_rdata};
  assign pkt_addr   = {b_rdata, off_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rsp_valid <= 1'b0;
      pkt_valid   <= 1'b0;
      win_err     <= 1'b0;
    end else begin
      if (pt_rd)            h_rsp_valid <= 1'b1;
      else if (h_rsp_ready) h_rsp_valid <= 1'b0;
      if (core_fire)        pkt_valid   <= 1'b1;
      else if (pkt_ready)   pkt_valid   <= 1'b0;
      if (h_fire && win == WIN_NONE) win_err <= 1'b1;
    end
    if (core_fire) begin
      off_q     <= core_addr[PAGE_OFF_W-1:0];
      pkt_write <= core_write;
      pkt_wdata <= core_wdata;
    end
  end
endmodule

// File: rtl/hwb_checker.sv
module hwb_checker #(
  parameter int HADDR_W    = 32,
  parameter int DATA_W     = 32,
  parameter int CORE_AW    = 20,
  parameter int PAGE_OFF_W = 12,
  parameter int PHYS_W     = 40
) (
  input logic clk,
  input logic rst,
  input logic h_rsp_valid,
  input logic h_rsp_ready,
  input logic [DATA_W-1:0] h_rsp_data,
  input logic ctl_valid,
  input logic ctl_ready,
  input logic [HADDR_W-1:0] ctl_addr,
  input logic blk_valid,
  input logic blk_ready,
  input logic [HADDR_W-1:0] blk_addr,
  input logic core_valid,
  input logic core_ready,
  input logic [CORE_AW-1:0] core_addr,
  input logic pkt_valid,
  input logic pkt_ready,
  input logic [PHYS_W-1:0] pkt_addr,
  input logic win_err,
  input logic pt_wr,
  input logic pt_rd,
  input logic [CORE_AW-PAGE_OFF_W-1:0] pt_idx
);
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
    ctl_valid && !ctl_ready |=> ctl_valid && $stable(ctl_addr)); // R7
  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (rst)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_addr)); // R7
  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_addr)); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    h_rsp_valid && !h_rsp_ready |=> h_rsp_valid && $stable(h_rsp_data)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    win_err |=> win_err); // R4
  AST_COLLIDE_STALL: assert property (@(posedge clk) disable iff (rst)
    pt_wr && core_valid && (pt_idx == core_addr[CORE_AW-1:PAGE_OFF_W]) |-> !core_ready); // R6
  AST_PKT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    core_valid && core_ready |=> pkt_valid); // R5
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    pt_rd |=> h_rsp_valid); // R3
endmodule

bind host_window_bridge hwb_checker #(
  .HADDR_W(HADDR_W), .DATA_W(DATA_W), .CORE_AW(CORE_AW),
  .PAGE_OFF_W(PAGE_OFF_W), .PHYS_W(PHYS_W)
) u_chk (
  .clk(clk), .rst(rst),
  .h_rsp_valid(h_rsp_valid), .h_rsp_ready(h_rsp_ready), .h_rsp_data(h_rsp_data),
  .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_addr(ctl_addr),
  .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_addr(blk_addr),
  .core_valid(core_valid), .core_ready(core_ready), .core_addr(core_addr),
  .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_addr(pkt_addr),
  .win_err(win_err), .pt_wr(pt_wr), .pt_rd(pt_rd), .pt_idx(pt_idx)
);

// File: tb/tb_host_window_bridge.sv
module tb_host_window_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CB = 32'h0000_0000, CS = 32'h0000_1000;
  localparam logic [31:0] BB = 32'h1000_0000, BS = 32'h1000_0000;
  localparam logic [31:0] PB = 32'h3000_0000;

  logic clk = 0, rst = 1;
  logic h_req_valid = 0, h_req_write = 0, h_rsp_ready = 0;
  logic [31:0] h_req_addr = 0, h_req_wdata = 0;
  logic ctl_ready = 0, blk_ready = 0, pkt_ready = 0;
  logic core_valid = 0, core_write = 0;
  logic [19:0] core_addr = 0;
  logic [31:0] core_wdata = 0;
  logic h_req_ready, h_rsp_valid, ctl_valid, ctl_write, blk_valid, blk_write;
  logic core_ready, pkt_valid, pkt_write, win_err;
  logic [31:0] h_rsp_data, ctl_addr, ctl_wdata, blk_addr, blk_wdata, pkt_wdata;
  logic [39:0] pkt_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_window_bridge dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [27:0] tbl [256];
  logic [64:0] ctl_q[$], blk_q[$];
  logic [72:0] pkt_q[$];
  logic [31:0] rsp_q[$];
  bit err_m = 0;
  bit gen_host = 0, gen_core = 0;
  int pt_only = 0;
  logic [72:0] pkt_prev;
  bit pkt_stall = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int win_of(input logic [31:0] a);
    if (a >= CB && a - CB < CS) return 0;
    if (a >= BB && a - BB < BS) return 1;
    if (a >= PB && a - PB < 32'd1024) return 2;
    return 3;
  endfunction

  function automatic logic [31:0] host_addr(input int kind);
    case (kind)
      0: return CB + ($urandom % CS);
      1: return BB + ($urandom % BS);
      2: return PB + ($urandom % 1024);
      default: return 32'h5000_0000 + ($urandom % 32'h1000);
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // evaluate handshakes for the coming edge; inputs are stable since the negedge
  task automatic evaluate();
    logic [127:0] e;
    chk(win_err == err_m, "R4 sticky error", win_err, err_m);
    if (pkt_stall) chk(pkt_valid && {pkt_write, pkt_addr, pkt_wdata} == pkt_prev,
                       "R7 packet hold", {pkt_write, pkt_addr, pkt_wdata}, pkt_prev);
    pkt_stall = pkt_valid && !pkt_ready;
    pkt_prev  = {pkt_write, pkt_addr, pkt_wdata};
    if (ctl_valid && ctl_ready) begin
      e = (ctl_q.size() != 0) ? ctl_q.pop_front() : 'x;
      chk({ctl_write, ctl_addr, ctl_wdata} === e[64:0], "R1 control link", {ctl_write, ctl_addr, ctl_wdata}, e);
    end
    if (blk_valid && blk_ready) begin
      e = (blk_q.size() != 0) ? blk_q.pop_front() : 'x;
      chk({blk_write, blk_addr, blk_wdata} === e[64:0], "R2 bulk link", {blk_write, blk_addr, blk_wdata}, e);
    end
    if (pkt_valid && pkt_ready) begin
      e = (pkt_q.size() != 0) ? pkt_q.pop_front() : 'x;
      chk({pkt_write, pkt_addr, pkt_wdata} === e[72:0], "R5 translated packet", {pkt_write, pkt_addr, pkt_wdata}, e);
    end
    if (h_rsp_valid && h_rsp_ready) begin
      e = (rsp_q.size() != 0) ? rsp_q.pop_front() : 'x;
      chk(h_rsp_data === e[31:0], "R3 table read", h_rsp_data, e);
    end
    if (h_req_valid && h_req_write && win_of(h_req_addr) == 2 && h_req_ready && core_valid
        && core_addr[19:12] == h_req_addr[9:2])
      chk(core_ready == 1'b0, "R6 collision stall", core_ready, 1'b0);
    if (core_valid && core_ready) begin
      pkt_q.push_back({core_write, tbl[core_addr[19:12]], core_addr[11:0], core_wdata});
      gen_core = 1;
    end
    if (h_req_valid && h_req_ready) begin
      case (win_of(h_req_addr))
        0: ctl_q.push_back({h_req_write, h_req_addr - CB, h_req_wdata});
        1: blk_q.push_back({h_req_write, h_req_addr - BB, h_req_wdata});
        2: if (h_req_write) tbl[h_req_addr[9:2]] = h_req_wdata[27:0];
           else rsp_q.push_back({4'h0, tbl[h_req_addr[9:2]]});
        default: err_m = 1;
      endcase
      gen_host = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R8: reset state
    chk({h_rsp_valid, ctl_valid, blk_valid, pkt_valid, win_err} == 5'b0, "R8 reset state",
        {h_rsp_valid, ctl_valid, blk_valid, pkt_valid, win_err}, 0);

    // load every table entry, upper data bits set to test truncation (R3)
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      h_req_valid = 1; h_req_write = 1;
      h_req_addr  = PB + i * 4 + ($urandom % 4);
      h_req_wdata = $urandom;
      h_rsp_ready = 1; ctl_ready = 1; blk_ready = 1; pkt_ready = 1;
      #1 evaluate();
    end

    // directed collision on entry 7 (R6), then a core request that must use the new entry
    @(negedge clk);
    h_req_valid = 1; h_req_write = 1; h_req_addr = PB + 7 * 4; h_req_wdata = 32'hFABC_DE12;
    core_valid = 1; core_write = 1; core_addr = {8'd7, 12'h345}; core_wdata = 32'h1111_2222;
    #1 evaluate();
    chk(core_ready == 1'b0, "R6 directed stall", core_ready, 0);
    @(negedge clk);
    h_req_valid = 0;
    #1 evaluate();
    @(negedge clk);
    core_valid = 0;
    #1 evaluate();

    // directed out-of-window request (R4)
    @(negedge clk);
    h_req_valid = 1; h_req_write = 0; h_req_addr = 32'h7000_0010;
    #1 evaluate();
    @(negedge clk);
    h_req_valid = 0;
    #1 evaluate();

    // random mixed traffic with random backpressure
    gen_host = 1; gen_core = 1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (gen_host) begin
        int kind;
        kind = $urandom % 6;
        h_req_valid = ($urandom % 4) != 0;
        h_req_write = (kind == 2) ? 1'b1 : ($urandom % 2);
        h_req_addr  = host_addr(kind > 3 ? (kind == 5 ? 3 : 2) : kind);
        h_req_wdata = $urandom;
        gen_host = !h_req_valid;
      end
      if (gen_core) begin
        core_valid = ($urandom % 4) != 0;
        core_write = $urandom % 2;
        core_addr  = $urandom;
        if ($urandom % 3 == 0) core_addr[19:12] = h_req_addr[9:2];
        core_wdata = $urandom;
        gen_core = !core_valid;
      end
      ctl_ready   = ($urandom % 10) < 6;
      blk_ready   = ($urandom % 10) < 6;
      pkt_ready   = ($urandom % 10) < 6;
      h_rsp_ready = ($urandom % 10) < 6;
      #1 evaluate();
    end

    // drain
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (gen_host) h_req_valid = 0;
      if (gen_core) core_valid = 0;
      ctl_ready = 1; blk_ready = 1; pkt_ready = 1; h_rsp_ready = 1;
      #1 evaluate();
    end
    chk(ctl_q.size() == 0 && blk_q.size() == 0, "R7 no lost forward", ctl_q.size() + blk_q.size(), 0);
    chk(pkt_q.size() == 0 && rsp_q.size() == 0, "R7 no lost packet", pkt_q.size() + rsp_q.size(), 0);
    chk(win_err == 1'b1, "R4 error still set", win_err, 1);
    finish_run();
  end
endmodule